// File: doc/BRIEF.md
# NAND Flash Bus Strobe Controller

This block sits between a simple single-master register bus and one raw 8-bit NAND flash device. Software programs one configuration word with three phase lengths (setup, active pulse, hold), a controller enable, an active-low chip-enable level and an ECC-restart request. It then writes command or address bytes to their own registers. Each such write becomes one complete flash write cycle, with the command latch or the address latch raised for the whole cycle and a write strobe in the middle of it.

Data-register writes send one byte with a write strobe. Data-register reads pulse the read strobe and capture the flash bus at the end of the pulse. A status register reports the flash ready/busy line after it passes through a synchroniser. Another register returns an externally computed ECC result. While a flash cycle runs, the host bus is held off through a ready handshake. Accesses to the other registers complete in the cycle they are presented.

Top module: `nand_strobe_ctrl`

## Requirements
- R1: Registers sit at byte offsets 0x00 (configuration), 0x04 (command), 0x08 (address), 0x0C (data), 0x10 (status) and 0x14 (ECC result). The configuration word packs:
  - the controller enable at bit 15;
  - the ECC-restart request at bit 12;
  - the chip-enable level at bit 11;
  - the setup field at bits [9:8];
  - the pulse field at bits [6:4];
  - the hold field at bits [2:0].

  Its value after reset reads 0x00000B77.
- R2: While enabled, a write to the command register produces one write cycle. `fl_cle` is high for the whole cycle, `fl_ale` stays low, `fl_we_n` is low only during the pulse phase, and `fl_dq_oe` is high with `fl_dq_out` holding the written byte throughout.
- R3: While enabled, a write to the address register produces the same cycle with `fl_ale` high instead of `fl_cle`.
- R4: While enabled, a write to the data register produces one write cycle with both `fl_cle` and `fl_ale` low and one `fl_we_n` pulse.
- R5: While enabled, a read of the data register keeps `fl_we_n` high and `fl_dq_oe` low, and drives `fl_re_n` low for the pulse phase. The value on `fl_dq_in` at the last clock of the pulse phase is returned in `bus_rdata[7:0]`, with the upper bits zero.
- R6: Each phase field holds its length minus one. The setup phase lasts setup+1 clocks (1 to 4), the pulse phase pulse+1 clocks (1 to 8) and the hold phase hold+1 clocks (1 to 8). The three phases run back to back from the clock after the request is accepted.
- R7: During a flash cycle `bus_ready` stays low. It rises for one clock after the hold phase ends. Accesses to the configuration, status and ECC registers (and reads of command or address) see `bus_ready` high in the cycle they are presented.
- R8: While bit 15 is clear, accesses to the command, address and data registers complete at once with no strobe or latch activity. A data read then returns 0.
- R9: `fl_ce_n` follows configuration bit 11 from the clock after the write. It is 1 (deselected) after reset.
- R10: Writing 1 to configuration bit 12 raises `ecc_restart` for exactly one clock, starting the clock after the write. Bit 12 always reads back 0.
- R11: Status bit 0 reads the level of `fl_rb` (1 = ready) as it was two clock edges earlier. A change is not visible after a single edge.
- R12: The ECC result register returns `ecc_value` zero-extended to the bus width.
- R13: When no flash cycle is running, `fl_we_n` and `fl_re_n` are high, `fl_cle`, `fl_ale` and `fl_dq_oe` are low. The two strobes are never low together, and the two latches are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Host access request, held until `bus_ready` |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid while `bus_ready` is high |
| bus_ready | output | 1 | Access completes in this cycle |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_cle | output | 1 | Command latch enable |
| fl_ale | output | 1 | Address latch enable |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_re_n | output | 1 | Read strobe, active low |
| fl_dq_out | output | IO_W | Byte driven to the flash |
| fl_dq_oe | output | 1 | Output enable for `fl_dq_out` |
| fl_dq_in | input | IO_W | Byte read from the flash |
| fl_rb | input | 1 | Flash ready/busy, 1 = ready |
| ecc_restart | output | 1 | One-clock request to restart the ECC accumulator |
| ecc_value | input | ECC_W | ECC result from the external generator |

## Verification
The sequencer is exercised with command, address, data-write and data-read cycles under the minimum timing (all fields zero), the maximum timing (3/7/7) and an uneven mix (1/2/4). An off-by-one in any single phase counter or a swapped field therefore shows up as a strobe edge one clock out of place.

For reads, the flash bus carries the wanted byte only during the last pulse clock and its complement at all other times. This separates sampling at the end of the pulse from sampling one clock early or late.

The disabled-controller accesses, the one-edge versus two-edge status reads and the repeated restart request distinguish a gated sequencer, a shallow synchroniser and a held restart level from the correct behaviour.

// File: rtl/nandc_pkg.sv
package nandc_pkg;

  // Register byte offsets
  localparam int OFS_CFG    = 'h00;
  localparam int OFS_CMD    = 'h04;
  localparam int OFS_ADR    = 'h08;
  localparam int OFS_DAT    = 'h0C;
  localparam int OFS_STATUS = 'h10;
  localparam int OFS_ECC    = 'h14;

  // Configuration word layout
  localparam int CFG_EN_BIT  = 15;
  localparam int CFG_ECC_BIT = 12;
  localparam int CFG_CE_BIT  = 11;
  localparam int SETUP_LSB   = 8;
  localparam int PULSE_LSB   = 4;
  localparam int HOLD_LSB    = 0;
  localparam int SETUP_W     = 2;
  localparam int PULSE_W     = 3;
  localparam int HOLD_W      = 3;
  localparam int CNT_W       = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_PULSE,
    ST_HOLD,
    ST_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    OP_CMD,
    OP_ADDR,
    OP_WDATA,
    OP_RDATA
  } flash_op_e;

endpackage

// File: rtl/nandc_rb_sync.sv
module nandc_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rb_in,
  output logic rb_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], rb_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rb_sync = chain_q[STAGES-1];

endmodule

// File: rtl/nandc_regs.sv
module nandc_regs
  import nandc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [DATA_W-1:0]  wdata,
  output logic               en,
  output logic               ce_n,
  output logic               ecc_restart,
  output logic [SETUP_W-1:0] t_setup,
  output logic [PULSE_W-1:0] t_pulse,
  output logic [HOLD_W-1:0]  t_hold,
  output logic [DATA_W-1:0]  cfg_word
);

  logic               en_q, en_d;
  logic               ce_n_q, ce_n_d;
  logic               ecc_q, ecc_d;
  logic [SETUP_W-1:0] setup_q, setup_d;
  logic [PULSE_W-1:0] pulse_q, pulse_d;
  logic [HOLD_W-1:0]  hold_q, hold_d;
  logic               unused_wdata;

  assign unused_wdata = ^{wdata[DATA_W-1:16], wdata[14:13], wdata[10],
                          wdata[7], wdata[3]};

  always_comb begin
    en_d    = en_q;
    ce_n_d  = ce_n_q;
    setup_d = setup_q;
    pulse_d = pulse_q;
    hold_d  = hold_q;
    ecc_d   = 1'b0;
    if (cfg_we) begin
      en_d    = wdata[CFG_EN_BIT];
      ce_n_d  = wdata[CFG_CE_BIT];
      setup_d = wdata[SETUP_LSB +: SETUP_W];
      pulse_d = wdata[PULSE_LSB +: PULSE_W];
      hold_d  = wdata[HOLD_LSB +: HOLD_W];
      ecc_d   = wdata[CFG_ECC_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      ce_n_q  <= 1'b1;
      ecc_q   <= 1'b0;
      setup_q <= '1;
      pulse_q <= '1;
      hold_q  <= '1;
    end else begin
      en_q    <= en_d;
      ce_n_q  <= ce_n_d;
      ecc_q   <= ecc_d;
      setup_q <= setup_d;
      pulse_q <= pulse_d;
      hold_q  <= hold_d;
    end
  end

  always_comb begin
    cfg_word                         = '0;
    cfg_word[CFG_EN_BIT]             = en_q;
    cfg_word[CFG_CE_BIT]             = ce_n_q;
    cfg_word[SETUP_LSB +: SETUP_W]   = setup_q;
    cfg_word[PULSE_LSB +: PULSE_W]   = pulse_q;
    cfg_word[HOLD_LSB +: HOLD_W]     = hold_q;
  end

  assign en          = en_q;
  assign ce_n        = ce_n_q;
  assign ecc_restart = ecc_q;
  assign t_setup     = setup_q;
  assign t_pulse     = pulse_q;
  assign t_hold      = hold_q;

  // R9
  ce_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ce_n_q) |-> $past(cfg_we));

  // R10
  ecc_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_q |-> $past(cfg_we));

endmodule

// File: rtl/nandc_seq.sv
module nandc_seq
  import nandc_pkg::*;
#(
  parameter int IO_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  flash_op_e          op,
  input  logic [IO_W-1:0]    wbyte,
  input  logic [SETUP_W-1:0] t_setup,
  input  logic [PULSE_W-1:0] t_pulse,
  input  logic [HOLD_W-1:0]  t_hold,
  input  logic [IO_W-1:0]    dq_in,
  output logic               idle,
  output logic               done,
  output logic               cle,
  output logic               ale,
  output logic               we_n,
  output logic               re_n,
  output logic               dq_oe,
  output logic [IO_W-1:0]    dq_out,
  output logic [IO_W-1:0]    rbyte
);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  flash_op_e        op_q, op_d;
  logic [IO_W-1:0]  byte_q, byte_d;
  logic             busy;
  logic             last;

  assign last = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    op_d    = op_q;
    byte_d  = byte_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_SETUP;
          cnt_d   = CNT_W'(t_setup);
          op_d    = op;
          byte_d  = wbyte;
        end
      end
      ST_SETUP: begin
        if (last) begin
          state_d = ST_PULSE;
          cnt_d   = CNT_W'(t_pulse);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_PULSE: begin
        if (last) begin
          state_d = ST_HOLD;
          cnt_d   = CNT_W'(t_hold);
          if (op_q == OP_RDATA) byte_d = dq_in;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_HOLD: begin
        if (last) state_d = ST_DONE;
        else      cnt_d   = cnt_q - 1'b1;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      op_q    <= OP_CMD;
      byte_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      op_q    <= op_d;
      byte_q  <= byte_d;
    end
  end

  assign busy   = (state_q == ST_SETUP) || (state_q == ST_PULSE) ||
                  (state_q == ST_HOLD);
  assign idle   = (state_q == ST_IDLE);
  assign done   = (state_q == ST_DONE);
  assign cle    = busy && (op_q == OP_CMD);
  assign ale    = busy && (op_q == OP_ADDR);
  assign we_n   = !((state_q == ST_PULSE) && (op_q != OP_RDATA));
  assign re_n   = !((state_q == ST_PULSE) && (op_q == OP_RDATA));
  assign dq_oe  = busy && (op_q != OP_RDATA);
  assign dq_out = byte_q;
  assign rbyte  = byte_q;

  // R13
  no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));

  // R13
  single_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));

  // R2
  oe_during_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> dq_oe);

  // R6
  setup_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> $past(busy));

  // R7
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> idle);

endmodule

// File: rtl/nand_strobe_ctrl.sv
module nand_strobe_ctrl
  import nandc_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 32,
  parameter int IO_W        = 8,
  parameter int ECC_W       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ready,
  output logic              fl_ce_n,
  output logic              fl_cle,
  output logic              fl_ale,
  output logic              fl_we_n,
  output logic              fl_re_n,
  output logic [IO_W-1:0]   fl_dq_out,
  output logic              fl_dq_oe,
  input  logic [IO_W-1:0]   fl_dq_in,
  input  logic              fl_rb,
  output logic              ecc_restart,
  input  logic [ECC_W-1:0]  ecc_value
);

  logic a_cfg, a_cmd, a_adr, a_dat, a_sts, a_ecc;
  logic is_flash, start, cfg_we;
  logic cfg_en, seq_idle, seq_done, rb_s;
  flash_op_e op;
  logic [SETUP_W-1:0] t_setup;
  logic [PULSE_W-1:0] t_pulse;
  logic [HOLD_W-1:0]  t_hold;
  logic [DATA_W-1:0]  cfg_word;
  logic [IO_W-1:0]    rbyte;

  assign a_cfg = (bus_addr == ADDR_W'(OFS_CFG));
  assign a_cmd = (bus_addr == ADDR_W'(OFS_CMD));
  assign a_adr = (bus_addr == ADDR_W'(OFS_ADR));
  assign a_dat = (bus_addr == ADDR_W'(OFS_DAT));
  assign a_sts = (bus_addr == ADDR_W'(OFS_STATUS));
  assign a_ecc = (bus_addr == ADDR_W'(OFS_ECC));

  assign is_flash = bus_req && ((bus_wr && (a_cmd || a_adr || a_dat)) ||
                                (!bus_wr && a_dat));
  assign op       = a_cmd ? OP_CMD : a_adr ? OP_ADDR :
                    bus_wr ? OP_WDATA : OP_RDATA;
  assign start    = is_flash && cfg_en && seq_idle;
  assign cfg_we   = bus_req && bus_wr && a_cfg;

  always_comb begin
    if (is_flash && cfg_en) bus_ready = seq_done;
    else                    bus_ready = bus_req;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_req && !bus_wr) begin
      if (a_cfg)      bus_rdata = cfg_word;
      else if (a_sts) bus_rdata = {{(DATA_W-1){1'b0}}, rb_s};
      else if (a_ecc) bus_rdata = {{(DATA_W-ECC_W){1'b0}}, ecc_value};
      else if (a_dat && cfg_en) bus_rdata = {{(DATA_W-IO_W){1'b0}}, rbyte};
    end
  end

  nandc_regs #(.DATA_W(DATA_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .wdata       (bus_wdata),
    .en          (cfg_en),
    .ce_n        (fl_ce_n),
    .ecc_restart (ecc_restart),
    .t_setup     (t_setup),
    .t_pulse     (t_pulse),
    .t_hold      (t_hold),
    .cfg_word    (cfg_word)
  );

  nandc_rb_sync #(.STAGES(SYNC_STAGES)) u_rb_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rb_in   (fl_rb),
    .rb_sync (rb_s)
  );

  nandc_seq #(.IO_W(IO_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .op      (op),
    .wbyte   (bus_wdata[IO_W-1:0]),
    .t_setup (t_setup),
    .t_pulse (t_pulse),
    .t_hold  (t_hold),
    .dq_in   (fl_dq_in),
    .idle    (seq_idle),
    .done    (seq_done),
    .cle     (fl_cle),
    .ale     (fl_ale),
    .we_n    (fl_we_n),
    .re_n    (fl_re_n),
    .dq_oe   (fl_dq_oe),
    .dq_out  (fl_dq_out),
    .rbyte   (rbyte)
  );

  // R8
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && seq_idle) |=> seq_idle);

  // R7
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && bus_req) |-> bus_ready);

endmodule

// File: tb/nand_strobe_ctrl_bench.sv
module nand_strobe_ctrl_bench;

  localparam logic [4:0] A_CFG = 5'h00, A_CMD = 5'h04, A_ADR = 5'h08,
                         A_DAT = 5'h0C, A_STS = 5'h10, A_ECC = 5'h14;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_req, bus_wr;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_ready;
  logic        fl_ce_n, fl_cle, fl_ale, fl_we_n, fl_re_n, fl_dq_oe;
  logic [7:0]  fl_dq_out, fl_dq_in;
  logic        fl_rb, ecc_restart;
  logic [23:0] ecc_value;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  nand_strobe_ctrl u_nand_strobe_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .fl_ce_n(fl_ce_n), .fl_cle(fl_cle),
    .fl_ale(fl_ale), .fl_we_n(fl_we_n), .fl_re_n(fl_re_n),
    .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in),
    .fl_rb(fl_rb), .ecc_restart(ecc_restart), .ecc_value(ecc_value)
  );

  task automatic chk(input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mkcfg(input bit en, input bit ce_n,
                                        input int s, input int p, input int h);
    return (32'(en) << 15) | (32'(ce_n) << 11) | (32'(s) << 8) |
           (32'(p) << 4) | 32'(h);
  endfunction

  task automatic idle_pins(input string tag);
    chk({tag, " cle"}, 32'(fl_cle), 0);
    chk({tag, " ale"}, 32'(fl_ale), 0);
    chk({tag, " we_n"}, 32'(fl_we_n), 1);
    chk({tag, " re_n"}, 32'(fl_re_n), 1);
    chk({tag, " oe"}, 32'(fl_dq_oe), 0);
  endtask

  // Called at a falling edge; returns at a falling edge after completion.
  task automatic reg_rw(input logic [4:0] a, input bit wr,
                        input logic [31:0] wd, input logic [31:0] exp,
                        input string tag);
    bus_req = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    #1;
    chk({tag, " ready"}, 32'(bus_ready), 1);
    if (!wr) chk({tag, " rdata"}, bus_rdata, exp);
    @(negedge clk);
    bus_req = 1'b0; bus_wr = 1'b0;
  endtask

  // Reference model of one flash cycle, compared pin by pin every clock.
  task automatic flash_op(input logic [4:0] a, input bit wr,
                          input logic [7:0] wb, input int s, input int p,
                          input int h, input logic [7:0] rv);
    bit cle_e = wr && (a == A_CMD);
    bit ale_e = wr && (a == A_ADR);
    int lens[3];
    lens[0] = s + 1; lens[1] = p + 1; lens[2] = h + 1;
    bus_req = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = {24'h0, wb};
    fl_dq_in = ~rv;
    for (int ph = 0; ph < 3; ph++) begin
      for (int i = 0; i < lens[ph]; i++) begin
        @(negedge clk);
        chk("R7 stall", 32'(bus_ready), 0);
        chk("R2 cle", 32'(fl_cle), 32'(cle_e));
        chk("R3 ale", 32'(fl_ale), 32'(ale_e));
        chk("R4 we_n", 32'(fl_we_n), 32'(!(ph == 1 && wr)));
        chk("R5 re_n", 32'(fl_re_n), 32'(!(ph == 1 && !wr)));
        chk("R4 oe", 32'(fl_dq_oe), 32'(wr));
        if (wr) chk("R2 dq_out", 32'(fl_dq_out), 32'(wb));
        fl_dq_in = (!wr && ph == 1 && i == lens[ph] - 1) ? rv : ~rv;
      end
    end
    @(negedge clk);
    chk("R6 ready at end", 32'(bus_ready), 1);
    if (!wr) chk("R5 rdata", bus_rdata, 32'(rv));
    idle_pins("R13");
    bus_req = 1'b0; bus_wr = 1'b0;
    @(negedge clk);
    idle_pins("R13");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R7 watchdog: actual hung expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_req = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    bus_wdata = '0; fl_dq_in = '0; fl_rb = 1'b1; ecc_value = 24'hABCDEF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    idle_pins("R13 reset");
    chk("R9 reset ce_n", 32'(fl_ce_n), 1);
    chk("R10 reset ecc", 32'(ecc_restart), 0);
    chk("R7 no req", 32'(bus_ready), 0);
    reg_rw(A_CFG, 0, 0, 32'h0000_0B77, "R1 reset cfg");
    reg_rw(A_STS, 0, 0, 32'h1, "R11 ready");
    reg_rw(A_ECC, 0, 0, 32'h00AB_CDEF, "R12 ecc");

    // Disabled controller
    reg_rw(A_CMD, 1, 32'h70, 0, "R8 cmd off");
    idle_pins("R8");
    reg_rw(A_DAT, 0, 0, 32'h0, "R8 read off");
    idle_pins("R8");
    reg_rw(A_CMD, 0, 0, 32'h0, "R7 cmd read");

    // Minimum timing
    reg_rw(A_CFG, 1, mkcfg(1, 0, 0, 0, 0), 0, "R1 cfg wr");
    chk("R9 ce_n low", 32'(fl_ce_n), 0);
    reg_rw(A_CFG, 0, 0, mkcfg(1, 0, 0, 0, 0), "R1 cfg rd");
    flash_op(A_CMD, 1, 8'h70, 0, 0, 0, 8'h00);
    flash_op(A_ADR, 1, 8'h12, 0, 0, 0, 8'h00);
    flash_op(A_DAT, 1, 8'hA5, 0, 0, 0, 8'h00);
    flash_op(A_DAT, 0, 8'h00, 0, 0, 0, 8'h3C);

    // Maximum timing
    reg_rw(A_CFG, 1, mkcfg(1, 0, 3, 7, 7), 0, "R6 cfg max");
    flash_op(A_CMD, 1, 8'h90, 3, 7, 7, 8'h00);
    flash_op(A_DAT, 0, 8'h00, 3, 7, 7, 8'hC3);

    // Uneven timing
    reg_rw(A_CFG, 1, mkcfg(1, 0, 1, 2, 4), 0, "R6 cfg mix");
    flash_op(A_ADR, 1, 8'h5A, 1, 2, 4, 8'h00);
    flash_op(A_DAT, 1, 8'h0F, 1, 2, 4, 8'h00);
    flash_op(A_DAT, 0, 8'h00, 1, 2, 4, 8'h81);

    // ECC restart pulse
    reg_rw(A_CFG, 1, mkcfg(1, 0, 1, 2, 4) | 32'h1000, 0, "R10 wr");
    chk("R10 pulse", 32'(ecc_restart), 1);
    @(negedge clk);
    chk("R10 pulse end", 32'(ecc_restart), 0);
    reg_rw(A_CFG, 0, 0, mkcfg(1, 0, 1, 2, 4), "R10 readback");
    chk("R10 no re-pulse", 32'(ecc_restart), 0);

    // Ready/busy synchroniser depth
    fl_rb = 1'b0;
    @(negedge clk);
    reg_rw(A_STS, 0, 0, 32'h1, "R11 one edge");
    reg_rw(A_STS, 0, 0, 32'h0, "R11 busy");
    fl_rb = 1'b1;
    @(negedge clk);
    @(negedge clk);
    reg_rw(A_STS, 0, 0, 32'h1, "R11 ready again");

    // Deselect chip, then disable and confirm silence
    reg_rw(A_CFG, 1, mkcfg(0, 1, 0, 0, 0), 0, "R9 deselect");
    chk("R9 ce_n high", 32'(fl_ce_n), 1);
    reg_rw(A_ADR, 1, 32'h33, 0, "R8 adr off");
    idle_pins("R8");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule